// File: doc/BRIEF.md
# Radio Transceiver Command Port

This block is the serial control port of a small sub-GHz FSK radio. A host talks to it as an SPI slave (mode 0: data sampled on the rising clock edge, changed on the falling edge). Every transaction carries one 16-bit command word, most significant bit first. The block samples the serial pins in its own system clock domain through synchronisers. Once the sixteenth bit has arrived it decodes the leading byte against a table of variable-length opcode prefixes and writes the payload into the matching shadow register. All shadow registers start from fixed power-on values.

The shadow registers and the fields decoded from them are presented as outputs to the rest of the radio. The power register is presented as an effective enable vector, because enabling the receiver or the transmitter implies other blocks. During every transaction the block shifts a 16-bit status word out on MISO. That word is built from live flags, from four latched event flags and from a 5-bit frequency-offset value. A status-read command acknowledges the latched flags that it reported. A software-reset command restores the power-on state. An unknown opcode changes nothing and raises a one-cycle error strobe.

Top module: `radioCtlPort`

## Requirements
- R1: After reset the shadow registers hold these values: configuration 0x08, power 0x08, frequency 0x680, data rate 0x23, FIFO/reset 0x80, AFC 0xF7, transceiver control 0x00 and PLL 0x77. Every other shadow register, and the transmit byte, holds zero. The power-on event flag is set.
- R2: A command takes effect only after its 16th bit has been sampled, and only once per transaction. Bits clocked in after the 16th are ignored.
- R3: If chip select rises before 16 bits have been sampled, the transaction is discarded and no register or strobe changes.
- R4: The leading byte is decoded with this priority: 0x80 configuration, 0x82 power, 0xA0-0xAF frequency, 0xC6 data rate, 0x90-0x97 receiver control (11 bits of payload), 0xC2 data filter, 0xCA FIFO/reset, 0xCE sync byte, 0xB0 FIFO read, 0xC4 AFC, 0x98-0x99 transceiver control, 0xCC PLL, 0xB8 transmit byte, 0xFE software reset, 0xE0-0xFF wake-up timer (13 bits of payload), 0xC8 duty cycle, 0xC0 battery detector, 0x00 status read. The exact 0xFE match wins over the 0xE0 range.
- R5: The frequency word is 12 bits: the low nibble of the leading byte above the whole second byte.
- R6: The effective power enable equals the stored power byte with two forcing rules. Bit 7 (receiver) forces bits 6, 4 and 3 on. Bit 5 (transmitter) forces bits 4 and 3 on.
- R7: At the falling edge of chip select a status word is captured. It is shifted out on MISO, MSB first, one bit per SCK falling edge, and zeros follow it. Bits 15..5 of the word are: transfer-ready, power-on, overrun, wake, external, low-battery, FIFO-empty, signal, data-quality, clock-lock and AFC-toggle. Bits 4..0 carry the AFC offset. MISO is low while chip select is high.
- R8: A completed status read clears each latched flag (power-on, wake, external, low-battery) that was set in the word it reported. A flag that was clear in that word and is raised during the read stays set.
- R9: A software reset restores every shadow register to its R1 value. It does not touch the latched flags.
- R10: An unrecognised leading byte leaves every register unchanged and raises `cmdError` for exactly one cycle.
- R11: The configuration byte yields band select (bits 5:4) and load capacitance (bits 3:0). The FIFO/reset byte yields trigger level (bits 7:4), one-byte sync (bit 3), fill mode (bits 2:1) and reset insensitivity (bit 0).
- R12: A transmit-byte command updates `txByte` and raises `txByteStb` for one cycle. A FIFO-read command raises `fifoRdStb` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSck | input | 1 | Serial clock from host |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial command data in |
| spiMiso | output | 1 | Serial status data out |
| xferReady | input | 1 | Live flag: FIFO has data / transmit register ready |
| overrun | input | 1 | Live flag: FIFO overflow / transmit underrun |
| fifoEmpty | input | 1 | Live flag: FIFO empty |
| signalHit | input | 1 | Live flag: signal strength above threshold |
| qualityOk | input | 1 | Live flag: data quality good |
| clockLock | input | 1 | Live flag: clock recovery locked |
| afcToggle | input | 1 | Live flag: AFC cycle toggle |
| afcOffset | input | 5 | Measured frequency offset |
| wakeEvt | input | 1 | Wake-up timer event pulse |
| extEvt | input | 1 | External interrupt event pulse |
| lowBatEvt | input | 1 | Low battery event pulse |
| cfgWord | output | 8 | Configuration shadow |
| bandSel | output | 2 | Band select field |
| loadCap | output | 4 | Crystal load capacitance field |
| pwrEnable | output | 8 | Effective power enables |
| freqWord | output | 12 | Carrier frequency word |
| rateWord | output | 8 | Data rate shadow |
| rxCtlWord | output | 11 | Receiver control shadow |
| filterWord | output | 8 | Data filter shadow |
| fifoWord | output | 8 | FIFO/reset shadow |
| fifoLevel | output | 4 | FIFO trigger level |
| syncOneByte | output | 1 | One-byte sync word selected |
| fillMode | output | 2 | FIFO fill mode |
| resetInsens | output | 1 | Reset-insensitive mode |
| syncWord | output | 8 | Sync byte shadow |
| afcWord | output | 8 | AFC shadow |
| txCtlWord | output | 8 | Transceiver control shadow |
| pllWord | output | 8 | PLL shadow |
| wakeWord | output | 13 | Wake-up timer shadow |
| dutyWord | output | 8 | Duty cycle shadow |
| batWord | output | 8 | Battery detector shadow |
| txByte | output | 8 | Last transmit byte |
| txByteStb | output | 1 | Transmit byte strobe |
| fifoRdStb | output | 1 | FIFO read strobe |
| cmdError | output | 1 | Unknown opcode strobe |

## Verification
The bench builds the block with its default two-stage pin synchronisers. It drives SCK with a half period of six system clocks, so every edge the synchroniser sees is resolved cycles before the next one. That margin lets the bench sample MISO just before each rising edge at a fixed, predictable point. Random leading bytes include every wildcard bit of the masked prefixes, so the 0xFE-against-0xE0 overlap is reached. The slow SCK also makes it practical to inject a wake event partway through a status read and to cut frames short or run them long.

// File: rtl/radioCtlPkg.sv
package radioCtlPkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ARG_W  = 13;
  localparam int FREQ_W = 12;
  localparam int RXC_W  = 11;
  localparam int STAT_W = WORD_W;

  localparam logic [BYTE_W-1:0] CFG_POR  = 8'h08;
  localparam logic [BYTE_W-1:0] PWR_POR  = 8'h08;
  localparam logic [FREQ_W-1:0] FREQ_POR = 12'h680;
  localparam logic [BYTE_W-1:0] RATE_POR = 8'h23;
  localparam logic [BYTE_W-1:0] FIFO_POR = 8'h80;
  localparam logic [BYTE_W-1:0] AFC_POR  = 8'hF7;
  localparam logic [BYTE_W-1:0] TXC_POR  = 8'h00;
  localparam logic [BYTE_W-1:0] PLL_POR  = 8'h77;

  typedef struct packed {
    logic cfg;
    logic pwr;
    logic freq;
    logic rate;
    logic rxc;
    logic filt;
    logic fifo;
    logic sync;
    logic fifoRd;
    logic afc;
    logic txc;
    logic pll;
    logic txWr;
    logic swRst;
    logic wake;
    logic duty;
    logic bat;
    logic stat;
    logic bad;
  } cmdStb_t;

  // Priority matters: the exact 0xFE match must be tested before the 0xE0 range.
  function automatic cmdStb_t decodeOp(input logic [BYTE_W-1:0] op);
    cmdStb_t s;
    s = '0;
    if (op == 8'h80)                   s.cfg    = 1'b1;
    else if (op == 8'h82)              s.pwr    = 1'b1;
    else if ((op & 8'hF0) == 8'hA0)    s.freq   = 1'b1;
    else if (op == 8'hC6)              s.rate   = 1'b1;
    else if ((op & 8'hF8) == 8'h90)    s.rxc    = 1'b1;
    else if (op == 8'hC2)              s.filt   = 1'b1;
    else if (op == 8'hCA)              s.fifo   = 1'b1;
    else if (op == 8'hCE)              s.sync   = 1'b1;
    else if (op == 8'hB0)              s.fifoRd = 1'b1;
    else if (op == 8'hC4)              s.afc    = 1'b1;
    else if ((op & 8'hFE) == 8'h98)    s.txc    = 1'b1;
    else if (op == 8'hCC)              s.pll    = 1'b1;
    else if (op == 8'hB8)              s.txWr   = 1'b1;
    else if (op == 8'hFE)              s.swRst  = 1'b1;
    else if ((op & 8'hE0) == 8'hE0)    s.wake   = 1'b1;
    else if (op == 8'hC8)              s.duty   = 1'b1;
    else if (op == 8'hC0)              s.bat    = 1'b1;
    else if (op == 8'h00)              s.stat   = 1'b1;
    else                               s.bad    = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/radioCtlCtrl.sv
module radioCtlCtrl
  import radioCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiSck,
  input  logic             spiCsN,
  input  logic             spiMosi,
  output cmdStb_t          stb,
  output logic [ARG_W-1:0] cmdArg,
  output logic             frameStart,
  output logic             sckFall,
  output logic             frameActive
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [SYNC_STAGES:0]   sckPipe;
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;
  logic                   sckS, sckPrev, csS, csPrev, mosiS, sckRise;
  logic [WORD_W-2:0]      shiftIn;
  logic [CNT_W-1:0]       bitCnt;
  logic [WORD_W-1:0]      fullWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-1:0], spiSck};
      csPipe   <= {csPipe[SYNC_STAGES-1:0], spiCsN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
    end
  end

  assign sckS    = sckPipe[SYNC_STAGES-1];
  assign sckPrev = sckPipe[SYNC_STAGES];
  assign csS     = csPipe[SYNC_STAGES-1];
  assign csPrev  = csPipe[SYNC_STAGES];
  assign mosiS   = mosiPipe[SYNC_STAGES-1];

  assign sckRise     = sckS & ~sckPrev & ~csS;
  assign sckFall     = ~sckS & sckPrev & ~csS;
  assign frameStart  = csPrev & ~csS;
  assign frameActive = ~csS;
  assign fullWord    = {shiftIn, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      bitCnt  <= '0;
      stb     <= '0;
      cmdArg  <= '0;
    end else begin
      stb <= '0;
      if (csS) begin
        bitCnt <= '0;
      end else if (sckRise && bitCnt < FULL_CNT) begin
        shiftIn <= fullWord[WORD_W-2:0];
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) begin
          stb    <= decodeOp(fullWord[WORD_W-1:BYTE_W]);
          cmdArg <= fullWord[ARG_W-1:0];
        end
      end
    end
  end

  // R2: the bit counter never runs past one command word
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);

  // R3: a deasserted chip select discards any partial frame
  a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0));

endmodule

// File: rtl/radioCtlData.sv
module radioCtlData
  import radioCtlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStb_t           stb,
  input  logic [ARG_W-1:0]  cmdArg,
  input  logic              frameStart,
  input  logic              sckFall,
  input  logic              frameActive,
  input  logic              xferReady,
  input  logic              overrun,
  input  logic              fifoEmpty,
  input  logic              signalHit,
  input  logic              qualityOk,
  input  logic              clockLock,
  input  logic              afcToggle,
  input  logic [4:0]        afcOffset,
  input  logic              wakeEvt,
  input  logic              extEvt,
  input  logic              lowBatEvt,
  output logic              spiMiso,
  output logic [BYTE_W-1:0] cfgWord,
  output logic [BYTE_W-1:0] pwrEnable,
  output logic [FREQ_W-1:0] freqWord,
  output logic [BYTE_W-1:0] rateWord,
  output logic [RXC_W-1:0]  rxCtlWord,
  output logic [BYTE_W-1:0] filterWord,
  output logic [BYTE_W-1:0] fifoWord,
  output logic [BYTE_W-1:0] syncWord,
  output logic [BYTE_W-1:0] afcWord,
  output logic [BYTE_W-1:0] txCtlWord,
  output logic [BYTE_W-1:0] pllWord,
  output logic [ARG_W-1:0]  wakeWord,
  output logic [BYTE_W-1:0] dutyWord,
  output logic [BYTE_W-1:0] batWord,
  output logic [BYTE_W-1:0] txByte,
  output logic              txByteStb,
  output logic              fifoRdStb,
  output logic              cmdError
);

  localparam int POR_BIT  = 14;
  localparam int WAKE_BIT = 12;
  localparam int EXT_BIT  = 11;
  localparam int LBAT_BIT = 10;

  logic [BYTE_W-1:0] pwrRaw;
  logic              porL, wakeL, extL, lowBatL;
  logic [STAT_W-1:0] statNow, statSnap, misoSh;
  logic              ackStat;

  // Shadow register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord    <= CFG_POR;
      pwrRaw     <= PWR_POR;
      freqWord   <= FREQ_POR;
      rateWord   <= RATE_POR;
      rxCtlWord  <= '0;
      filterWord <= '0;
      fifoWord   <= FIFO_POR;
      syncWord   <= '0;
      afcWord    <= AFC_POR;
      txCtlWord  <= TXC_POR;
      pllWord    <= PLL_POR;
      wakeWord   <= '0;
      dutyWord   <= '0;
      batWord    <= '0;
      txByte     <= '0;
      txByteStb  <= 1'b0;
      fifoRdStb  <= 1'b0;
      cmdError   <= 1'b0;
    end else begin
      txByteStb <= stb.txWr;
      fifoRdStb <= stb.fifoRd;
      cmdError  <= stb.bad;
      if (stb.swRst) begin
        cfgWord    <= CFG_POR;
        pwrRaw     <= PWR_POR;
        freqWord   <= FREQ_POR;
        rateWord   <= RATE_POR;
        rxCtlWord  <= '0;
        filterWord <= '0;
        fifoWord   <= FIFO_POR;
        syncWord   <= '0;
        afcWord    <= AFC_POR;
        txCtlWord  <= TXC_POR;
        pllWord    <= PLL_POR;
        wakeWord   <= '0;
        dutyWord   <= '0;
        batWord    <= '0;
        txByte     <= '0;
      end else begin
        if (stb.cfg)  cfgWord    <= cmdArg[BYTE_W-1:0];
        if (stb.pwr)  pwrRaw     <= cmdArg[BYTE_W-1:0];
        if (stb.freq) freqWord   <= cmdArg[FREQ_W-1:0];
        if (stb.rate) rateWord   <= cmdArg[BYTE_W-1:0];
        if (stb.rxc)  rxCtlWord  <= cmdArg[RXC_W-1:0];
        if (stb.filt) filterWord <= cmdArg[BYTE_W-1:0];
        if (stb.fifo) fifoWord   <= cmdArg[BYTE_W-1:0];
        if (stb.sync) syncWord   <= cmdArg[BYTE_W-1:0];
        if (stb.afc)  afcWord    <= cmdArg[BYTE_W-1:0];
        if (stb.txc)  txCtlWord  <= cmdArg[BYTE_W-1:0];
        if (stb.pll)  pllWord    <= cmdArg[BYTE_W-1:0];
        if (stb.wake) wakeWord   <= cmdArg;
        if (stb.duty) dutyWord   <= cmdArg[BYTE_W-1:0];
        if (stb.bat)  batWord    <= cmdArg[BYTE_W-1:0];
        if (stb.txWr) txByte     <= cmdArg[BYTE_W-1:0];
      end
    end
  end

  // Receiver and transmitter imply their supporting blocks
  always_comb begin
    pwrEnable = pwrRaw;
    if (pwrRaw[7]) pwrEnable = pwrEnable | 8'h58;
    if (pwrRaw[5]) pwrEnable = pwrEnable | 8'h18;
  end

  assign statNow = {xferReady, porL, overrun, wakeL, extL, lowBatL,
                    fifoEmpty, signalHit, qualityOk, clockLock, afcToggle,
                    afcOffset};
  assign ackStat = stb.stat;

  // Latched event flags: acknowledge only what the read actually reported
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porL    <= 1'b1;
      wakeL   <= 1'b0;
      extL    <= 1'b0;
      lowBatL <= 1'b0;
    end else begin
      porL    <= porL    & ~(ackStat & statSnap[POR_BIT]);
      wakeL   <= (wakeL  & ~(ackStat & statSnap[WAKE_BIT])) | wakeEvt;
      extL    <= (extL   & ~(ackStat & statSnap[EXT_BIT]))  | extEvt;
      lowBatL <= (lowBatL & ~(ackStat & statSnap[LBAT_BIT])) | lowBatEvt;
    end
  end

  // Status snapshot and MISO shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statSnap <= '0;
      misoSh   <= '0;
    end else if (frameStart) begin
      statSnap <= statNow;
      misoSh   <= statNow;
    end else if (sckFall) begin
      misoSh <= {misoSh[STAT_W-2:0], 1'b0};
    end
  end

  assign spiMiso = frameActive & misoSh[STAT_W-1];

  // R10: an unknown opcode leaves the shadows alone
  a_r10_error_no_change: assert property (@(posedge clk) disable iff (!rstN)
    stb.bad |=> ($stable(cfgWord) && $stable(pwrRaw) && $stable(freqWord)
                 && $stable(afcWord) && $stable(fifoWord)));

  // R9: software reset lands on the power-on values
  a_r9_soft_reset_values: assert property (@(posedge clk) disable iff (!rstN)
    stb.swRst |=> (cfgWord == CFG_POR && freqWord == FREQ_POR
                   && afcWord == AFC_POR && pllWord == PLL_POR));

  // R5: the frequency word takes the 12 payload bits
  a_r5_freq_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.freq |=> (freqWord == $past(cmdArg[FREQ_W-1:0])));

  // R12: transmit strobe lasts a single cycle
  a_r12_tx_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    txByteStb |=> !txByteStb);

endmodule

// File: rtl/radioCtlPort.sv
module radioCtlPort
  import radioCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSck,
  input  logic        spiCsN,
  input  logic        spiMosi,
  output logic        spiMiso,
  input  logic        xferReady,
  input  logic        overrun,
  input  logic        fifoEmpty,
  input  logic        signalHit,
  input  logic        qualityOk,
  input  logic        clockLock,
  input  logic        afcToggle,
  input  logic [4:0]  afcOffset,
  input  logic        wakeEvt,
  input  logic        extEvt,
  input  logic        lowBatEvt,
  output logic [7:0]  cfgWord,
  output logic [1:0]  bandSel,
  output logic [3:0]  loadCap,
  output logic [7:0]  pwrEnable,
  output logic [11:0] freqWord,
  output logic [7:0]  rateWord,
  output logic [10:0] rxCtlWord,
  output logic [7:0]  filterWord,
  output logic [7:0]  fifoWord,
  output logic [3:0]  fifoLevel,
  output logic        syncOneByte,
  output logic [1:0]  fillMode,
  output logic        resetInsens,
  output logic [7:0]  syncWord,
  output logic [7:0]  afcWord,
  output logic [7:0]  txCtlWord,
  output logic [7:0]  pllWord,
  output logic [12:0] wakeWord,
  output logic [7:0]  dutyWord,
  output logic [7:0]  batWord,
  output logic [7:0]  txByte,
  output logic        txByteStb,
  output logic        fifoRdStb,
  output logic        cmdError
);

  cmdStb_t          stb;
  logic [ARG_W-1:0] cmdArg;
  logic             frameStart, sckFall, frameActive;

  radioCtlCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .stb(stb), .cmdArg(cmdArg),
    .frameStart(frameStart), .sckFall(sckFall), .frameActive(frameActive)
  );

  radioCtlData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdArg(cmdArg),
    .frameStart(frameStart), .sckFall(sckFall), .frameActive(frameActive),
    .xferReady(xferReady), .overrun(overrun), .fifoEmpty(fifoEmpty),
    .signalHit(signalHit), .qualityOk(qualityOk), .clockLock(clockLock),
    .afcToggle(afcToggle), .afcOffset(afcOffset), .wakeEvt(wakeEvt),
    .extEvt(extEvt), .lowBatEvt(lowBatEvt), .spiMiso(spiMiso),
    .cfgWord(cfgWord), .pwrEnable(pwrEnable), .freqWord(freqWord),
    .rateWord(rateWord), .rxCtlWord(rxCtlWord), .filterWord(filterWord),
    .fifoWord(fifoWord), .syncWord(syncWord), .afcWord(afcWord),
    .txCtlWord(txCtlWord), .pllWord(pllWord), .wakeWord(wakeWord),
    .dutyWord(dutyWord), .batWord(batWord), .txByte(txByte),
    .txByteStb(txByteStb), .fifoRdStb(fifoRdStb), .cmdError(cmdError)
  );

  assign bandSel     = cfgWord[5:4];
  assign loadCap     = cfgWord[3:0];
  assign fifoLevel   = fifoWord[7:4];
  assign syncOneByte = fifoWord[3];
  assign fillMode    = fifoWord[2:1];
  assign resetInsens = fifoWord[0];

endmodule

// File: tb/sim_radioCtlPort.sv
module sim_radioCtlPort;

  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0, spiMiso;
  logic xferReady = 0, overrun = 0, fifoEmpty = 0, signalHit = 0;
  logic qualityOk = 0, clockLock = 0, afcToggle = 0;
  logic [4:0] afcOffset = '0;
  logic wakeEvt = 0, extEvt = 0, lowBatEvt = 0;
  logic [7:0] cfgWord, pwrEnable, rateWord, filterWord, fifoWord, syncWord;
  logic [7:0] afcWord, txCtlWord, pllWord, dutyWord, batWord, txByte;
  logic [1:0] bandSel, fillMode;
  logic [3:0] loadCap, fifoLevel;
  logic [11:0] freqWord;
  logic [10:0] rxCtlWord;
  logic [12:0] wakeWord;
  logic syncOneByte, resetInsens, txByteStb, fifoRdStb, cmdError;

  radioCtlPort u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  int errSeen = 0, frdSeen = 0, txsSeen = 0;
  int errExp = 0, frdExp = 0, txsExp = 0;

  always @(posedge clk) begin
    if (cmdError)  errSeen++;
    if (fifoRdStb) frdSeen++;
    if (txByteStb) txsSeen++;
  end

  // Expected model
  logic [7:0]  eCfg, ePwr, eRate, eFilt, eFifo, eSync, eAfc, eTxc, ePll, eDuty, eBat, eTx;
  logic [11:0] eFreq;
  logic [10:0] eRxc;
  logic [12:0] eWake;
  logic eP, eW, eE, eL;

  task automatic porModel();
    eCfg = 8'h08; ePwr = 8'h08; eFreq = 12'h680; eRate = 8'h23; eRxc = '0;
    eFilt = '0; eFifo = 8'h80; eSync = '0; eAfc = 8'hF7; eTxc = 8'h00;
    ePll = 8'h77; eWake = '0; eDuty = '0; eBat = '0; eTx = '0;
  endtask

  function automatic logic [7:0] effPwr(input logic [7:0] p);
    logic [7:0] r;
    r = p;
    if (p[7]) r = r | 8'h58;
    if (p[5]) r = r | 8'h18;
    return r;
  endfunction

  function automatic logic [15:0] expStat();
    return {xferReady, eP, overrun, eW, eE, eL, fifoEmpty, signalHit,
            qualityOk, clockLock, afcToggle, afcOffset};
  endfunction

  // Kind codes follow the R4 priority table; 99 = unknown
  function automatic int kindOf(input logic [7:0] op);
    if (op == 8'h80) return 0;
    if (op == 8'h82) return 1;
    if (op[7:4] == 4'hA) return 2;
    if (op == 8'hC6) return 3;
    if (op[7:3] == 5'b10010) return 4;
    if (op == 8'hC2) return 5;
    if (op == 8'hCA) return 6;
    if (op == 8'hCE) return 7;
    if (op == 8'hB0) return 8;
    if (op == 8'hC4) return 9;
    if (op[7:1] == 7'b1001100) return 10;
    if (op == 8'hCC) return 11;
    if (op == 8'hB8) return 12;
    if (op == 8'hFE) return 13;
    if (op[7:5] == 3'b111) return 14;
    if (op == 8'hC8) return 15;
    if (op == 8'hC0) return 16;
    if (op == 8'h00) return 17;
    return 99;
  endfunction

  task automatic applyModel(input logic [15:0] w, input logic [15:0] rep);
    logic [7:0] b;
    b = w[7:0];
    case (kindOf(w[15:8]))
      0: eCfg = b;
      1: ePwr = b;
      2: eFreq = w[11:0];
      3: eRate = b;
      4: eRxc = w[10:0];
      5: eFilt = b;
      6: eFifo = b;
      7: eSync = b;
      8: frdExp++;
      9: eAfc = b;
      10: eTxc = b;
      11: ePll = b;
      12: begin eTx = b; txsExp++; end
      13: porModel();
      14: eWake = w[12:0];
      15: eDuty = b;
      16: eBat = b;
      17: begin
        if (rep[14]) eP = 1'b0;
        if (rep[12]) eW = 1'b0;
        if (rep[11]) eE = 1'b0;
        if (rep[10]) eL = 1'b0;
      end
      default: errExp++;
    endcase
  endtask

  task automatic chk(input string req, input string nm, input logic [15:0] act,
                     input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, nm, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "cfgWord", 16'(cfgWord), 16'(eCfg));
    chk({req, "/R11"}, "bandSel", 16'(bandSel), 16'(eCfg[5:4]));
    chk({req, "/R11"}, "loadCap", 16'(loadCap), 16'(eCfg[3:0]));
    chk({req, "/R6"}, "pwrEnable", 16'(pwrEnable), 16'(effPwr(ePwr)));
    chk({req, "/R5"}, "freqWord", 16'(freqWord), 16'(eFreq));
    chk(req, "rateWord", 16'(rateWord), 16'(eRate));
    chk(req, "rxCtlWord", 16'(rxCtlWord), 16'(eRxc));
    chk(req, "filterWord", 16'(filterWord), 16'(eFilt));
    chk(req, "fifoWord", 16'(fifoWord), 16'(eFifo));
    chk({req, "/R11"}, "fifoFields",
        16'({fifoLevel, syncOneByte, fillMode, resetInsens}), 16'(eFifo));
    chk(req, "syncWord", 16'(syncWord), 16'(eSync));
    chk(req, "afcWord", 16'(afcWord), 16'(eAfc));
    chk(req, "txCtlWord", 16'(txCtlWord), 16'(eTxc));
    chk(req, "pllWord", 16'(pllWord), 16'(ePll));
    chk(req, "wakeWord", 16'(wakeWord), 16'(eWake));
    chk(req, "dutyWord", 16'(dutyWord), 16'(eDuty));
    chk(req, "batWord", 16'(batWord), 16'(eBat));
    chk({req, "/R12"}, "txByte", 16'(txByte), 16'(eTx));
    chk({req, "/R12"}, "txStrobes", 16'(txsSeen), 16'(txsExp));
    chk({req, "/R12"}, "fifoRdStrobes", 16'(frdSeen), 16'(frdExp));
    chk({req, "/R10"}, "errStrobes", 16'(errSeen), 16'(errExp));
  endtask

  // One SPI transaction; evAt >= 0 pulses wakeEvt after that bit
  task automatic spiXfer(input logic [15:0] w, input int nBits, input int evAt,
                         output logic [15:0] rx, output logic [15:0] tailOr);
    rx = '0; tailOr = '0;
    @(negedge clk) spiCsN = 1'b0;
    repeat (SCK_HALF) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      spiMosi = (i < 16) ? w[15-i] : 1'($urandom_range(0, 1));
      repeat (SCK_HALF) @(negedge clk);
      if (i < 16) rx[15-i] = spiMiso;
      else tailOr[0] = tailOr[0] | spiMiso;
      spiSck = 1'b1;
      if (i == evAt) begin
        @(negedge clk) wakeEvt = 1'b1;
        @(negedge clk) wakeEvt = 1'b0;
        repeat (SCK_HALF - 2) @(negedge clk);
      end else begin
        repeat (SCK_HALF) @(negedge clk);
      end
      spiSck = 1'b0;
    end
    repeat (SCK_HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (SCK_HALF + 6) @(negedge clk);
  endtask

  // Full command with model update and MISO check
  task automatic doCmd(input logic [15:0] w, input string req);
    logic [15:0] rep, rx, tl;
    rep = expStat();
    spiXfer(w, 16, -1, rx, tl);
    chk({req, "/R7"}, "misoWord", rx, rep);
    applyModel(w, rep);
    checkAll(req);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  function automatic logic [7:0] pickOp();
    logic [7:0] bad [6];
    bad = '{8'h81, 8'h01, 8'hC1, 8'hB4, 8'h50, 8'h7F};
    case ($urandom_range(0, 19))
      0: return 8'h80;   1: return 8'h82;
      2: return 8'hA0 | 8'($urandom_range(0, 15));
      3: return 8'hC6;
      4: return 8'h90 | 8'($urandom_range(0, 7));
      5: return 8'hC2;   6: return 8'hCA;   7: return 8'hCE;   8: return 8'hB0;
      9: return 8'hC4;
      10: return 8'h98 | 8'($urandom_range(0, 1));
      11: return 8'hCC;  12: return 8'hB8;  13: return 8'hFE;
      14: return 8'hE0 | 8'($urandom_range(0, 31));
      15: return 8'hC8;  16: return 8'hC0;  17: return 8'h00;
      default: return bad[$urandom_range(0, 5)];
    endcase
  endfunction

  initial begin
    logic [15:0] rx, tl, rep;
    void'($urandom(32'd20240611));
    porModel();
    eP = 1'b1; eW = 1'b0; eE = 1'b0; eL = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: power-on state
    checkAll("R1");
    chk("R7", "misoIdle", 16'(spiMiso), 16'h0);

    // R1 + R7 + R8: first status read reports and then acknowledges power-on
    afcOffset = 5'h15; clockLock = 1'b1;
    doCmd(16'h0000, "R8");
    chk("R8", "porAfterRead", 16'(eP), 16'h0);
    rep = expStat();
    spiXfer(16'h0000, 16, -1, rx, tl);
    chk("R8", "porCleared", 16'(rx[14]), 16'h0);
    chk("R7", "afcOffsetField", 16'(rx[4:0]), 16'h15);

    // R3: aborted frame changes nothing
    spiXfer(16'h80FF, 10, -1, rx, tl);
    checkAll("R3");

    // R2: extra bits after the 16th are ignored, MISO shifts zeros
    spiXfer(16'h8234, 20, -1, rx, tl);
    applyModel(16'h8234, 16'h0);
    checkAll("R2");
    chk("R7", "misoTail", tl, 16'h0);

    // R6: forcing rules
    doCmd(16'h8280, "R6");
    chk("R6", "rxForce", 16'(pwrEnable), 16'h00D8);
    doCmd(16'h8220, "R6");
    chk("R6", "txForce", 16'(pwrEnable), 16'h0038);

    // R5: frequency composition
    doCmd(16'hA7C3, "R5");
    chk("R5", "freq", 16'(freqWord), 16'h07C3);

    // R4: 0xFE wins over wake range; 0xE5 is wake timer
    doCmd(16'hE5AB, "R4");
    chk("R4", "wake", 16'(wakeWord), 16'h05AB);
    doCmd(16'hFE12, "R9");
    chk("R9", "cfgPor", 16'(cfgWord), 16'h0008);
    chk("R9", "wakePor", 16'(wakeWord), 16'h0000);

    // R10: unknown opcode
    doCmd(16'h8100, "R10");

    // R12: transmit byte and FIFO read
    doCmd(16'hB85A, "R12");
    doCmd(16'hB000, "R12");

    // R11: fields
    doCmd(16'hCA9B, "R11");
    doCmd(16'h803E, "R11");

    // R8: event raised during a read survives the acknowledge
    extEvt = 1'b1; @(negedge clk) extEvt = 1'b0; eE = 1'b1;
    rep = expStat();
    spiXfer(16'h0000, 16, 5, rx, tl);
    chk("R8", "extReported", 16'(rx[11]), 16'h1);
    chk("R8", "wakeNotInWord", 16'(rx[12]), 16'h0);
    applyModel(16'h0000, rep);
    eW = 1'b1;
    rep = expStat();
    spiXfer(16'h0000, 16, -1, rx, tl);
    chk("R8", "wakeSurvives", rx, rep);
    applyModel(16'h0000, rep);

    // Random traffic
    for (int n = 0; n < 150; n++) begin
      logic [15:0] w;
      {xferReady, overrun, fifoEmpty, signalHit, qualityOk, clockLock, afcToggle}
        = 7'($urandom_range(0, 127));
      afcOffset = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk) lowBatEvt = 1'b1;
        @(negedge clk) lowBatEvt = 1'b0;
        eL = 1'b1;
      end
      w = {pickOp(), 8'($urandom_range(0, 255))};
      doCmd(w, "R4");
    end

    finishRun();
  end

endmodule